// File: doc/BRIEF.md
# Packet-Command PIO Burst Sequencer

This block is the device-side control for a packet command carried over a PIO data register. The host sets a byte-count limit in the two cylinder registers, optionally sets the DMA select bit in the feature register, and then writes the packet command code. The block shows busy for one cycle. It then requests the 12-byte command packet, which the host writes as six 16-bit words.

The packet is decoded only far enough to find a READ(10) opcode and its 16-bit block count. The count is converted to bytes at 2048 bytes per block. The data phase is split into bursts. Before each burst the block writes the burst length into the byte-count registers, raises DRQ and raises the interrupt. The host then reads the burst one word at a time. Each word is assembled from two bytes pulled from a byte-stream source. A final interrupt with DRQ clear closes the command.

When DMA is selected, the block only reports the choice on an output and moves no data. An unknown opcode ends the command with an abort error.

Top module: `atapi_pio_seq`

## Requirements
- R1: After reset, status reads 0x40 (DRDY only; BSY bit 7, DRQ bit 3, ERR bit 0 clear), the error register is 0, irq is low and dma_sel is low.
- R2: When command 0xA0 is written to address 7 while idle, the limit is captured from address 4 (low byte) and address 5 (high byte), and feature bit 0 from address 1. Status is 0xC0 (BSY and DRDY) in the cycle after the write and 0x48 (DRQ and DRDY) in the cycle after that.
- R3: The packet is six word writes to address 0; in each word the low byte is the earlier packet byte. Byte 0 is the opcode, 0x28 selects a read, and bytes 7 (high) and 8 (low) give the block count. The transfer is that count times 2048 bytes.
- R4: Each burst length is the remaining byte count when that count is not above the limit, and otherwise the limit with bit 0 cleared.
- R5: A limit of 0 acts as a limit of 0xFFFE.
- R6: Before each burst, byte_cnt holds that burst's length and status reads 0x48 with irq raised. BSY and DRQ are never set together, and byte_cnt stays fixed while DRQ is held.
- R7: Each data word takes its low byte from the earlier stream byte. While a word is being fetched (including stalls of the source), status shows BSY and DRQ is clear, and src_ready is high only then.
- R8: After the last word of the last burst, status reads 0x40 and irq is raised. The interrupt never rises while BSY is set.
- R9: A block count of 0 ends the command straight after the packet with status 0x40 and irq raised, and no byte is taken from the source.
- R10: An opcode other than 0x28 ends the command with status 0x41, error register 0x04 (abort, bit 2) and irq raised.
- R11: With feature bit 0 set, dma_sel goes high, no byte is taken from the source, no interrupt is raised, and status returns to 0x40 after the packet.
- R12: A pulse on host_rd_status clears irq, unless irq is being set in the same cycle. Accepting a new command also clears irq, the error register and dma_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 3 | Register address for writes |
| host_wdata | input | 16 | Write data (byte registers use bits 7:0) |
| host_rd_data | input | 1 | Host pops the current data word |
| host_rd_status | input | 1 | Host status read, clears irq |
| data_word | output | 16 | Current data word for the host |
| status | output | 8 | Status register |
| error_reg | output | 8 | Error register |
| byte_cnt | output | 16 | Byte-count register readback |
| irq | output | 1 | Interrupt request |
| dma_sel | output | 1 | DMA selected for this command |
| src_byte | input | 8 | Data stream byte |
| src_valid | input | 1 | Stream byte valid |
| src_ready | output | 1 | Block takes stream byte |

## Verification
The bench goes after the burst split with an odd limit below the transfer size. A design that forgot the rounding would report 2047 and leave a half word. It also covers a zero limit, where a literal reading would give an empty burst and hang. A zero block count is covered too; a design that skipped that case would raise DRQ with nothing to send. Source stalls check that no word is assembled from a missing byte. The DMA and bad-opcode cases check that neither one touches the stream. A new command must clear a stale interrupt, or the host would see a burst that does not exist.

// File: rtl/atapi_seq_pkg.sv
package atapi_seq_pkg;
   localparam int SB_BSY  = 7;
   localparam int SB_DRDY = 6;
   localparam int SB_DRQ  = 3;
   localparam int SB_ERR  = 0;
   localparam int EB_ABRT = 2;

   localparam logic [2:0] RA_DATA = 3'd0;
   localparam logic [2:0] RA_FEAT = 3'd1;
   localparam logic [2:0] RA_BCLO = 3'd4;
   localparam logic [2:0] RA_BCHI = 3'd5;
   localparam logic [2:0] RA_CMD  = 3'd7;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_CMDBSY,
      SQ_PKT,
      SQ_DECODE,
      SQ_SETUP,
      SQ_LOAD,
      SQ_XFER
   } seq_state_e;
endpackage

// File: rtl/atapi_pkt_gather.sv
module atapi_pkt_gather #(
   parameter int PKT_WORDS   = 6,
   parameter int OPC_BYTE    = 0,
   parameter int CNT_HI_BYTE = 7,
   parameter int CNT_LO_BYTE = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clear,
   input  logic        wr_en,
   input  logic [15:0] wr_word,
   output logic        last,
   output logic [7:0]  opcode,
   output logic [15:0] blocks
);
   localparam int PKT_BITS = PKT_WORDS * 16;
   localparam int IDX_W    = $clog2(PKT_WORDS + 1);

   if (CNT_LO_BYTE >= PKT_WORDS * 2 || CNT_HI_BYTE >= PKT_WORDS * 2) begin : g_bad_layout
      $error("count field lies outside the packet");
   end

   logic [PKT_BITS-1:0] pkt_q;
   logic [IDX_W-1:0]    idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pkt_q <= '0;
         idx_q <= '0;
      end else if (clear) begin
         idx_q <= '0;
      end else if (wr_en) begin
         for (int i = 0; i < PKT_WORDS; i++) begin
            if (idx_q == IDX_W'(i)) pkt_q[i*16 +: 16] <= wr_word;
         end
         idx_q <= idx_q + 1'b1;
      end
   end

   assign last   = (idx_q == IDX_W'(PKT_WORDS - 1));
   assign opcode = pkt_q[OPC_BYTE*8 +: 8];
   assign blocks = {pkt_q[CNT_HI_BYTE*8 +: 8], pkt_q[CNT_LO_BYTE*8 +: 8]};
endmodule

// File: rtl/atapi_burst_len.sv
module atapi_burst_len #(
   parameter int               REM_W      = 27,
   parameter int               LIMIT_W    = 16,
   parameter logic [LIMIT_W-1:0] ZERO_LIMIT = 16'hFFFE
) (
   input  logic [REM_W-1:0]   remain,
   input  logic [LIMIT_W-1:0] limit_raw,
   output logic [LIMIT_W-1:0] burst_len
);
   if (REM_W <= LIMIT_W) begin : g_bad_width
      $error("remaining count must be wider than the limit");
   end

   logic [LIMIT_W-1:0] lim_eff;
   logic               fits;

   always_comb begin
      lim_eff   = (limit_raw == '0) ? ZERO_LIMIT : limit_raw;
      fits      = (remain <= {{(REM_W-LIMIT_W){1'b0}}, lim_eff});
      burst_len = fits ? remain[LIMIT_W-1:0] : {lim_eff[LIMIT_W-1:1], 1'b0};
   end
endmodule

// File: rtl/atapi_byte_packer.sv
module atapi_byte_packer #(
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic [7:0]  src_byte,
   input  logic        src_valid,
   output logic        src_ready,
   output logic [15:0] word,
   output logic        done
);
   logic       active_q, have_q, done_q;
   logic [7:0] first_q;
   logic [15:0] word_q, pair;

   if (LOW_FIRST) begin : g_low_first
      assign pair = {src_byte, first_q};
   end else begin : g_high_first
      assign pair = {first_q, src_byte};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         have_q   <= 1'b0;
         done_q   <= 1'b0;
         first_q  <= '0;
         word_q   <= '0;
      end else begin
         done_q <= 1'b0;
         if (start) begin
            active_q <= 1'b1;
            have_q   <= 1'b0;
         end else if (active_q && src_valid) begin
            if (!have_q) begin
               first_q <= src_byte;
               have_q  <= 1'b1;
            end else begin
               word_q   <= pair;
               active_q <= 1'b0;
               done_q   <= 1'b1;
            end
         end
      end
   end

   assign src_ready = active_q;
   assign word      = word_q;
   assign done      = done_q;
endmodule

// File: rtl/atapi_pio_seq.sv
module atapi_pio_seq
   import atapi_seq_pkg::*;
#(
   parameter int   LIMIT_W   = 16,
   parameter int   BLK_LOG2  = 11,
   parameter int   BLKCNT_W  = 16,
   parameter int   PKT_WORDS = 6,
   parameter logic [7:0] PKT_CMD  = 8'hA0,
   parameter logic [7:0] READ_OPC = 8'h28,
   parameter bit   LOW_FIRST = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        host_wr,
   input  logic [2:0]  host_addr,
   input  logic [15:0] host_wdata,
   input  logic        host_rd_data,
   input  logic        host_rd_status,
   output logic [15:0] data_word,
   output logic [7:0]  status,
   output logic [7:0]  error_reg,
   output logic [15:0] byte_cnt,
   output logic        irq,
   output logic        dma_sel,
   input  logic [7:0]  src_byte,
   input  logic        src_valid,
   output logic        src_ready
);
   localparam int REM_W = BLKCNT_W + BLK_LOG2;
   localparam logic [LIMIT_W-1:0] ZERO_LIMIT = {{(LIMIT_W-1){1'b1}}, 1'b0};

   if (LIMIT_W != 16 || BLKCNT_W != 16) begin : g_bad_regs
      $error("register interface is sixteen bits wide");
   end

   seq_state_e         st_q;
   logic [LIMIT_W-1:0] cyl_q, lim_q, words_q, burst_len;
   logic [REM_W-1:0]   rem_q;
   logic               feat_q, dma_q, irq_q, abrt_q, first_q;
   logic               cmd_hit, pkt_wr, pkt_last, pack_start, pack_done;
   logic [7:0]         opcode;
   logic [15:0]        blocks;
   logic [15:0]        pack_word;

   assign cmd_hit = host_wr && host_addr == RA_CMD && host_wdata[7:0] == PKT_CMD
                    && st_q == SQ_IDLE;
   assign pkt_wr  = host_wr && host_addr == RA_DATA && st_q == SQ_PKT;
   assign pack_start = (st_q == SQ_SETUP) ||
                       (st_q == SQ_XFER && host_rd_data && words_q > LIMIT_W'(1));

   atapi_pkt_gather #(.PKT_WORDS(PKT_WORDS)) u_gather (
      .clk(clk), .rst_n(rst_n), .clear(cmd_hit), .wr_en(pkt_wr),
      .wr_word(host_wdata), .last(pkt_last), .opcode(opcode), .blocks(blocks)
   );

   atapi_burst_len #(.REM_W(REM_W), .LIMIT_W(LIMIT_W), .ZERO_LIMIT(ZERO_LIMIT)) u_len (
      .remain(rem_q), .limit_raw(lim_q), .burst_len(burst_len)
   );

   atapi_byte_packer #(.LOW_FIRST(LOW_FIRST)) u_pack (
      .clk(clk), .rst_n(rst_n), .start(pack_start), .src_byte(src_byte),
      .src_valid(src_valid), .src_ready(src_ready), .word(pack_word), .done(pack_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= SQ_IDLE;
         cyl_q   <= '0;
         lim_q   <= '0;
         words_q <= '0;
         rem_q   <= '0;
         feat_q  <= 1'b0;
         dma_q   <= 1'b0;
         irq_q   <= 1'b0;
         abrt_q  <= 1'b0;
         first_q <= 1'b0;
      end else begin
         if (host_rd_status) irq_q <= 1'b0;
         if (host_wr && host_addr == RA_FEAT) feat_q <= host_wdata[0];
         if (host_wr && host_addr == RA_BCLO) cyl_q[7:0]  <= host_wdata[7:0];
         if (host_wr && host_addr == RA_BCHI) cyl_q[15:8] <= host_wdata[7:0];
         unique case (st_q)
            SQ_IDLE: if (cmd_hit) begin
               lim_q  <= cyl_q;
               dma_q  <= feat_q;
               irq_q  <= 1'b0;
               abrt_q <= 1'b0;
               st_q   <= SQ_CMDBSY;
            end
            SQ_CMDBSY: st_q <= SQ_PKT;
            SQ_PKT: if (pkt_wr && pkt_last) st_q <= SQ_DECODE;
            SQ_DECODE: begin
               rem_q <= {blocks, {BLK_LOG2{1'b0}}};
               if (opcode != READ_OPC) begin
                  abrt_q <= 1'b1;
                  irq_q  <= 1'b1;
                  st_q   <= SQ_IDLE;
               end else if (dma_q) begin
                  st_q <= SQ_IDLE;
               end else if (blocks == '0) begin
                  irq_q <= 1'b1;
                  st_q  <= SQ_IDLE;
               end else begin
                  st_q <= SQ_SETUP;
               end
            end
            SQ_SETUP: begin
               cyl_q   <= burst_len;
               words_q <= burst_len >> 1;
               first_q <= 1'b1;
               st_q    <= SQ_LOAD;
            end
            SQ_LOAD: if (pack_done) begin
               if (first_q) irq_q <= 1'b1;
               first_q <= 1'b0;
               st_q    <= SQ_XFER;
            end
            SQ_XFER: if (host_rd_data) begin
               rem_q   <= rem_q - REM_W'(2);
               words_q <= words_q - 1'b1;
               if (words_q > LIMIT_W'(1)) begin
                  st_q <= SQ_LOAD;
               end else if (rem_q != REM_W'(2)) begin
                  st_q <= SQ_SETUP;
               end else begin
                  irq_q <= 1'b1;
                  st_q  <= SQ_IDLE;
               end
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   always_comb begin
      status          = '0;
      status[SB_DRDY] = 1'b1;
      status[SB_BSY]  = st_q inside {SQ_CMDBSY, SQ_DECODE, SQ_SETUP, SQ_LOAD};
      status[SB_DRQ]  = st_q inside {SQ_PKT, SQ_XFER};
      status[SB_ERR]  = abrt_q;
      error_reg          = '0;
      error_reg[EB_ABRT] = abrt_q;
   end

   assign data_word = pack_word;
   assign byte_cnt  = cyl_q;
   assign irq       = irq_q;
   assign dma_sel   = dma_q;
endmodule

// File: rtl/atapi_pio_seq_chk.sv
module atapi_pio_seq_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        host_wr,
   input logic [2:0]  host_addr,
   input logic [15:0] host_wdata,
   input logic        host_rd_data,
   input logic        host_rd_status,
   input logic [15:0] data_word,
   input logic [7:0]  status,
   input logic [7:0]  error_reg,
   input logic [15:0] byte_cnt,
   input logic        irq,
   input logic        dma_sel,
   input logic [7:0]  src_byte,
   input logic        src_valid,
   input logic        src_ready
);
   logic cmd_seen;
   assign cmd_seen = host_wr && host_addr == 3'd7 && host_wdata[7:0] == 8'hA0
                     && !status[7] && !status[3];

   p_cmd_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_seen |=> status[7]);
   p_busy_drq_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(status[7] && status[3]));
   p_count_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (status[3] && $past(status[3]) && !$past(host_wr)) |-> $stable(byte_cnt));
   p_src_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      src_ready |-> (status[7] && !status[3]));
   p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> !status[7]);
   p_err_abrt_r10: assert property (@(posedge clk) disable iff (!rst_n)
      status[0] |-> error_reg[2]);
   p_dma_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      dma_sel |-> !src_ready);
   p_irq_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> ($past(host_rd_status) || $past(cmd_seen)));
endmodule

bind atapi_pio_seq atapi_pio_seq_chk u_chk (.*);

// File: tb/atapi_pio_seq_bench.sv
module atapi_pio_seq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic [2:0]  host_addr = '0;
   logic [15:0] host_wdata = '0;
   logic        host_rd_data = 1'b0;
   logic        host_rd_status = 1'b0;
   logic [15:0] data_word;
   logic [7:0]  status, error_reg;
   logic [15:0] byte_cnt;
   logic        irq, dma_sel, src_ready, src_valid;
   logic [7:0]  src_byte;

   int tests = 0, fails = 0;
   int src_idx = 0, exp_idx = 0, cyc = 0;
   bit stall = 1'b0, finished = 1'b0;
   logic [15:0] exp_q[$];

   always #2 clk = ~clk;

   function automatic logic [7:0] pat(input int k);
      return 8'((k * 13) ^ (k >> 7));
   endfunction

   assign src_byte  = pat(src_idx);
   assign src_valid = !(stall && cyc[1:0] == 2'b01);

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (src_ready && src_valid) src_idx <= src_idx + 1;
   end

   atapi_pio_seq u_atapi_pio_seq (.*);

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // scoreboard monitor: compares each popped word with the queue head
   always @(negedge clk) begin
      #1;
      if (host_rd_data) begin
         if (exp_q.size() == 0) check(1'b0, "R7 unexpected word", data_word, 0);
         else begin
            logic [15:0] e;
            e = exp_q.pop_front();
            check(data_word == e && status[3], "R7 data word", data_word, e);
         end
      end
   end

   task automatic hw(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic wait_for(input bit use_irq, input logic [7:0] mask, input logic [7:0] val);
      for (int i = 0; i < 4000; i++) begin
         if (use_irq ? irq : ((status & mask) == val)) return;
         @(negedge clk);
      end
      check(1'b0, "wait timeout", status, val);
   endtask

   task automatic clear_irq();
      @(negedge clk); host_rd_status = 1'b1;
      @(negedge clk); host_rd_status = 1'b0;
      check(irq == 1'b0, "R12 status read clears irq", irq, 0);
   endtask

   task automatic run_cmd(input logic [15:0] lim, input logic [7:0] opc,
                          input logic [15:0] blocks, input bit feat);
      int rem;
      int lim_eff;
      hw(3'd1, {15'd0, feat});
      hw(3'd4, {8'd0, lim[7:0]});
      hw(3'd5, {8'd0, lim[15:8]});
      hw(3'd7, 16'h00A0);
      check(status == 8'hC0, "R2 busy after command", status, 8'hC0);
      check(irq == 1'b0, "R12 command clears irq", irq, 0);
      @(negedge clk);
      check(status == 8'h48, "R2 packet request", status, 8'h48);
      hw(3'd0, {8'h00, opc});
      hw(3'd0, 16'h0000);
      hw(3'd0, 16'h0000);
      hw(3'd0, {blocks[15:8], 8'h00});
      hw(3'd0, {8'h00, blocks[7:0]});
      hw(3'd0, 16'h0000);
      if (opc != 8'h28) begin
         wait_for(1'b1, 8'h00, 8'h00);
         check(status == 8'h41, "R10 abort status", status, 8'h41);
         check(error_reg == 8'h04, "R10 abort code", error_reg, 8'h04);
         check(src_idx == exp_idx, "R10 no stream use", src_idx, exp_idx);
         return;
      end
      if (feat) begin
         wait_for(1'b0, 8'h88, 8'h00);
         repeat (3) @(negedge clk);
         check(status == 8'h40 && !irq, "R11 dma no data, no irq", {irq, status}, 8'h40);
         check(dma_sel == 1'b1, "R11 dma select", dma_sel, 1);
         check(src_idx == exp_idx, "R11 no stream use", src_idx, exp_idx);
         return;
      end
      rem = int'(blocks) * 2048;
      lim_eff = (lim == 0) ? 16'hFFFE : int'(lim);
      while (rem > 0) begin
         int len;
         len = (rem <= lim_eff) ? rem : (lim_eff & ~1);
         for (int w = 0; w < len / 2; w++) begin
            exp_q.push_back({pat(exp_idx + 1), pat(exp_idx)});
            exp_idx += 2;
         end
         wait_for(1'b1, 8'h00, 8'h00);
         check(status == 8'h48, "R6 burst status", status, 8'h48);
         check(int'(byte_cnt) == len, "R4 R5 burst length", byte_cnt, len);
         clear_irq();
         for (int w = 0; w < len / 2; w++) begin
            wait_for(1'b0, 8'h88, 8'h08);
            host_rd_data = 1'b1;
            @(negedge clk);
            host_rd_data = 1'b0;
         end
         rem -= len;
      end
      wait_for(1'b1, 8'h00, 8'h00);
      check(status == 8'h40, "R8 completion status", status, 8'h40);
      check(exp_q.size() == 0, "R3 R7 all words read", exp_q.size(), 0);
      check(src_idx == exp_idx, "R9 R3 stream bytes used", src_idx, exp_idx);
      clear_irq();
   endtask

   always @(posedge clk) begin
      if (cyc > 150000 && !finished) begin
         finished = 1'b1;
         check(1'b0, "watchdog", cyc, 150000);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(status == 8'h40 && error_reg == 0, "R1 reset status", status, 8'h40);
      check(!irq && !dma_sel, "R1 reset irq and dma", {irq, dma_sel}, 0);
      run_cmd(16'd5120, 8'h28, 16'd3, 1'b0);   // R4 two bursts 5120 + 1024
      run_cmd(16'd2047, 8'h28, 16'd1, 1'b0);   // R4 odd limit: 2046 + 2
      run_cmd(16'd2049, 8'h28, 16'd1, 1'b0);   // R4 odd limit above remainder
      run_cmd(16'd0, 8'h28, 16'd1, 1'b0);      // R5 zero limit
      run_cmd(16'd0, 8'h28, 16'd0, 1'b0);      // R9 empty transfer
      run_cmd(16'd512, 8'h12, 16'd1, 1'b0);    // R10 bad opcode, irq left set
      run_cmd(16'd512, 8'h28, 16'd1, 1'b1);    // R11 dma select, R12 clears old irq
      stall = 1'b1;
      run_cmd(16'd1000, 8'h28, 16'd1, 1'b0);   // R7 source stalls
      check(dma_sel == 1'b0 && error_reg == 0, "R12 command clears dma and error",
            {dma_sel, error_reg}, 0);
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule